// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading translation entries from memory. A request with a valid/ready handshake supplies the linear address and a mode bit. In paged mode the walk reads two entries in turn. The first is a directory entry, located from a root base input and the top ten address bits. The second is a table entry, located from the directory entry's base and the middle ten address bits. The block then joins the table entry's page base with the untouched low twelve bits of the request.

In the compatibility mode only the low 20 bits of the request matter. A single table entry is read, indexed by bits 19 to 12, from a separate table base input. Its page base is joined with the low twelve bits. Each entry is one 32-bit word. Bits 31 to 12 are a 4 KB-aligned base, bit 0 is the present flag, and bits 11 to 1 are ignored. An entry with the present flag clear ends the walk with a fault that carries the original linear address.

Table reads go out on a request/response memory port. One walk is handled at a time, and the result appears as a one-cycle response pulse.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: From the clock edge that accepts a request (`req_valid` and `req_ready` both 1), `req_ready` stays 0 until `rsp_valid` has been 1 for exactly one cycle. `req_ready` is 1 again in the cycle after that pulse.
- R3: In paged mode (`req_v86`=0), the first memory read goes to `{dir_base[31:12], 12'b0} + vaddr[31:22]*4`. Bits 11:0 of `dir_base` are ignored.
- R4: When the directory entry has bit 0 set, the second read goes to `{pde[31:12], 12'b0} + vaddr[21:12]*4`. Bits 11:1 of any entry are ignored.
- R5: When the final entry has bit 0 set, the response has `rsp_fault`=0 and `rsp_addr` = `{pte[31:12], vaddr[11:0]}`.
- R6: A directory entry with bit 0 clear ends the walk after one read. The response has `rsp_fault`=1 and `rsp_addr` equal to the full requested linear address.
- R7: A table entry with bit 0 clear ends the walk after two reads. The response has `rsp_fault`=1 and `rsp_addr` equal to the full requested linear address.
- R8: In compatibility mode (`req_v86`=1), exactly one read goes to `{v86_base[31:12], 12'b0} + vaddr[19:12]*4`. The result is `{pte[31:12], vaddr[11:0]}`, or a fault as in R7. Bits 31:20 of the request have no effect on the read address or the physical result.
- R9: A memory read request holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is 1.
- R10: `dir_base`, `v86_base` and `req_vaddr` are sampled at acceptance. Changing them during a walk does not change its reads or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address to translate |
| req_v86 | input | 1 | 1 selects the single-level 20-bit mode |
| dir_base | input | 32 | Root directory base (bits 31:12 used) |
| v86_base | input | 32 | Table base for compatibility mode (bits 31:12 used) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | 1 when a not-present entry was found |
| rsp_addr | output | 32 | Physical address, or the faulting linear address |

## Verification
Paged walks sweep forty directory indices, spread by an odd stride so every low-five-bit pattern occurs, against sixteen table indices with varied page offsets. The memory model marks entries absent when index bits 4:0 equal 3. This separates faults at the directory level from faults at the table level, counted by reads, and from successful translations. The compatibility mode is run over all 256 table indices with random-looking upper address bits, which shows that those bits are ignored. Some walks rewrite both base inputs and the request address mid-walk to show they are captured at acceptance. The memory stalls `mem_req_ready` and varies read latency, so the handshake and response timing vary across walks.

// File: rtl/pgwalk_pkg.sv
// Shared types for the page table walker.
// Assumes: one walk at a time; states are encoded compactly.
package pgwalk_pkg;

    // Walk sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } walk_st_e;

    // Which entry address the datapath forms
    typedef enum logic [1:0] {
        SEL_DIR,
        SEL_TBL,
        SEL_V86
    } ent_sel_e;

endpackage

// File: rtl/pgwalk_fsm.sv
// Walk sequencer: accepts one request, issues up to two entry reads,
// stops early on a not-present entry, and pulses the result for one cycle.
// Assumes: the memory returns exactly one response per accepted read and
// no response arrives outside a waiting state.
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_v86,
    output logic     req_ready,
    input  logic     mem_req_ready,
    input  logic     mem_rsp_valid,
    input  logic     ent_present,
    output logic     mem_req_valid,
    output ent_sel_e sel,
    output logic     cap_req,
    output logic     cap_dir_ent,
    output logic     cap_tbl_ent,
    output logic     rsp_valid,
    output logic     rsp_fault
);

    walk_st_e state_q, state_d;
    logic     v86_q;
    logic     fault_q;

    // Handshake and strobe decode from the current state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
        rsp_valid     = (state_q == ST_DONE);
        cap_req       = req_ready && req_valid;
        cap_dir_ent   = (state_q == ST_DIR_WAIT) && mem_rsp_valid;
        cap_tbl_ent   = (state_q == ST_TBL_WAIT) && mem_rsp_valid;
        sel           = SEL_DIR;
        if ((state_q == ST_TBL_REQ) || (state_q == ST_TBL_WAIT))
            sel = v86_q ? SEL_V86 : SEL_TBL;
    end

    // Next-state selection for the walk
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_v86 ? ST_TBL_REQ : ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_req_ready) state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) state_d = ent_present ? ST_TBL_REQ : ST_DONE;
            ST_TBL_REQ:  if (mem_req_ready) state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, mode and fault registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            v86_q   <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cap_req) begin
                v86_q   <= req_v86;
                fault_q <= 1'b0;
            end
            if ((cap_dir_ent || cap_tbl_ent) && !ent_present)
                fault_q <= 1'b1;
        end
    end

    assign rsp_fault = fault_q;

    // R2
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R6
    dir_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_dir_ent && !ent_present) |=> (rsp_valid && rsp_fault && !mem_req_valid));

    // R7
    tbl_fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_tbl_ent && !ent_present) |=> (rsp_valid && rsp_fault));

endmodule

// File: rtl/pgwalk_dp.sv
// Walk datapath: captures the request and base inputs at acceptance,
// forms entry addresses as base + index*entry size, keeps the fetched
// page bases and builds the result address.
// Assumes: entries are one word of 2**ENT_SH bytes with a 4 KB-aligned base.
module pgwalk_dp
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int DIR_IDX_W   = 10,
    parameter int TBL_IDX_W   = 10,
    parameter int V86_IDX_W   = 8,
    parameter int PRESENT_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req,
    input  logic              cap_dir_ent,
    input  logic              cap_tbl_ent,
    input  ent_sel_e          sel,
    input  logic              fault,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:0] v86_base,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              ent_present,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] rsp_addr
);

    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int ENT_SH = 2;
    localparam int V86_W  = OFF_W + V86_IDX_W;
    localparam int TBL_LO = OFF_W;
    localparam int DIR_LO = OFF_W + TBL_IDX_W;

    logic [ADDR_W-1:0] va_q;
    logic [BASE_W-1:0] dbase_q, vbase_q, dent_q, tent_q;
    logic [ADDR_W-1:0] dir_idx, tbl_idx, v86_idx;

    // Capture request, bases and the fetched entry bases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            dbase_q <= '0;
            vbase_q <= '0;
            dent_q  <= '0;
            tent_q  <= '0;
        end else begin
            if (cap_req) begin
                va_q    <= req_vaddr;
                dbase_q <= dir_base[ADDR_W-1:OFF_W];
                vbase_q <= v86_base[ADDR_W-1:OFF_W];
            end
            if (cap_dir_ent) dent_q <= mem_rsp_data[ADDR_W-1:OFF_W];
            if (cap_tbl_ent) tent_q <= mem_rsp_data[ADDR_W-1:OFF_W];
        end
    end

    // Index fields widened to address width
    always_comb begin
        dir_idx = ADDR_W'(va_q[DIR_LO +: DIR_IDX_W]);
        tbl_idx = ADDR_W'(va_q[TBL_LO +: TBL_IDX_W]);
        v86_idx = ADDR_W'(va_q[V86_W-1 -: V86_IDX_W]);
    end

    // Entry address: selected table base plus index scaled to entry size
    always_comb begin
        case (sel)
            SEL_TBL: mem_req_addr = {dent_q,  {OFF_W{1'b0}}} + (tbl_idx << ENT_SH);
            SEL_V86: mem_req_addr = {vbase_q, {OFF_W{1'b0}}} + (v86_idx << ENT_SH);
            default: mem_req_addr = {dbase_q, {OFF_W{1'b0}}} + (dir_idx << ENT_SH);
        endcase
    end

    // Present flag of the returning entry and the result address
    always_comb begin
        ent_present = mem_rsp_data[PRESENT_BIT];
        rsp_addr    = fault ? va_q : {tent_q, va_q[OFF_W-1:0]};
    end

    logic unused_bits;
    assign unused_bits = ^{dir_base[OFF_W-1:0], v86_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:0]};

    // R10
    va_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_req |=> $stable(va_q));

endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker top: joins the sequencer and the datapath.
// Assumes: the memory answers every accepted read exactly once, in order.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int DIR_IDX_W   = 10,
    parameter int TBL_IDX_W   = 10,
    parameter int V86_IDX_W   = 8,
    parameter int PRESENT_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_v86,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:0] v86_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ADDR_W-1:0] rsp_addr
);

    ent_sel_e sel;
    logic     cap_req, cap_dir_ent, cap_tbl_ent, ent_present;

    pgwalk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_v86       (req_v86),
        .req_ready     (req_ready),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (ent_present),
        .mem_req_valid (mem_req_valid),
        .sel           (sel),
        .cap_req       (cap_req),
        .cap_dir_ent   (cap_dir_ent),
        .cap_tbl_ent   (cap_tbl_ent),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault)
    );

    pgwalk_dp #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .DIR_IDX_W   (DIR_IDX_W),
        .TBL_IDX_W   (TBL_IDX_W),
        .V86_IDX_W   (V86_IDX_W),
        .PRESENT_BIT (PRESENT_BIT)
    ) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_req      (cap_req),
        .cap_dir_ent  (cap_dir_ent),
        .cap_tbl_ent  (cap_tbl_ent),
        .sel          (sel),
        .fault        (rsp_fault),
        .req_vaddr    (req_vaddr),
        .dir_base     (dir_base),
        .v86_base     (v86_base),
        .mem_rsp_data (mem_rsp_data),
        .ent_present  (ent_present),
        .mem_req_addr (mem_req_addr),
        .rsp_addr     (rsp_addr)
    );

    // R9
    memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2
    no_rsp_while_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rsp_valid));

endmodule

// File: tb/pgwalk_top_tb.sv
// Bench: sweeps paged and compatibility walks against a computed memory.
module pgwalk_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_v86 = 1'b0;
    logic [31:0] dir_base = 32'h0012_3ABC;
    logic [31:0] v86_base = 32'h0ABC_D5A5;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] DIR_B = 32'h0012_3ABC;
    localparam logic [31:0] V86_B = 32'h0ABC_D5A5;

    always #5 clk = ~clk;

    pgwalk_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_v86(req_v86), .dir_base(dir_base), .v86_base(v86_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
    );

    // Memory content as a function of address; index bits 4:0 == 3 is absent
    function automatic logic [31:0] ent(input logic [31:0] a);
        logic [19:0] b;
        b = a[21:2] * 20'd7 + 20'h00135;
        return {b, 11'h2A5, (a[6:2] != 5'd3)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: stalls ready, variable latency, logs accepted reads
    int          cyc = 0;
    bit          hs_prev = 0, pend = 0;
    int          cnt = 0, rd_n = 0;
    logic [31:0] hs_addr = '0, pend_a = '0;
    logic [31:0] rd_log [4];
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (hs_prev) begin pend = 1; cnt = cyc % 3; pend_a = hs_addr; end
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ent(pend_a);
                pend = 0;
            end else cnt--;
        end
        mem_req_ready = (cyc % 3) != 1;
        hs_prev = mem_req_valid && mem_req_ready;
        if (hs_prev) begin
            if (rd_n < 4) rd_log[rd_n] = mem_req_addr;
            rd_n++;
            hs_addr = mem_req_addr;
        end
    end

    task automatic do_walk(input logic [31:0] va, input bit v86, input bit disturb);
        logic [31:0] a1, e1, a2, e2, exp_addr;
        bit          exp_fault;
        int          exp_n, waits;
        bit          busy_ok;
        @(negedge clk);
        rd_n = 0;
        req_valid = 1'b1; req_vaddr = va; req_v86 = v86;
        if (!v86) begin
            a1 = {DIR_B[31:12], 12'b0} + {20'b0, va[31:22], 2'b0};
            e1 = ent(a1);
            a2 = {e1[31:12], 12'b0} + {20'b0, va[21:12], 2'b0};
            e2 = ent(a2);
            exp_n = e1[0] ? 2 : 1;
            exp_fault = !(e1[0] && e2[0]);
        end else begin
            a1 = {V86_B[31:12], 12'b0} + {22'b0, va[19:12], 2'b0};
            e1 = ent(a1);
            a2 = a1; e2 = e1;
            exp_n = 1;
            exp_fault = !e1[0];
        end
        exp_addr = exp_fault ? va : {e2[31:12], va[11:0]};
        chk(req_ready == 1'b1, "R2 ready before accept", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (disturb) begin
            dir_base = ~DIR_B; v86_base = ~V86_B; req_vaddr = ~va;
        end
        waits = 0; busy_ok = 1;
        while (!rsp_valid && waits < 200) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            waits++;
        end
        if (waits >= 200) chk(0, "watchdog rsp_valid", 32'd0, 32'd1);
        chk(busy_ok, "R2 busy during walk", {31'b0, busy_ok}, 32'd1);
        chk(rd_n == exp_n, exp_fault && exp_n == 1 && !v86 ? "R6 read count" :
            (v86 ? "R8 read count" : "R7 read count"), rd_n, exp_n);
        chk(rd_log[0] == a1, v86 ? "R8 table read addr" :
            (disturb ? "R10 dir read addr" : "R3 dir read addr"), rd_log[0], a1);
        if (exp_n == 2)
            chk(rd_log[1] == a2, "R4 table read addr", rd_log[1], a2);
        chk(rsp_fault == exp_fault, exp_fault ? "R6/R7 fault flag" : "R5 fault flag",
            {31'b0, rsp_fault}, {31'b0, exp_fault});
        chk(rsp_addr == exp_addr, exp_fault ? "R7 fault addr" :
            (v86 ? "R8 phys addr" : "R5 phys addr"), rsp_addr, exp_addr);
        dir_base = DIR_B; v86_base = V86_B;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R2 pulse then ready",
            {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog global", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
        // R3 R4 R5 R6 R7 R10: paged sweep
        for (int d = 0; d < 40; d++) begin
            for (int t = 0; t < 16; t++) begin
                logic [9:0]  di = 10'((d * 37) % 1024);
                logic [9:0]  ti = 10'((t * 67) % 1024);
                logic [11:0] of = 12'((d * t * 13 + d) % 4096);
                do_walk({di, ti, of}, 1'b0, (d % 4) == 0 && t < 4);
            end
        end
        // R8 R10: compatibility sweep over all indices
        for (int i = 0; i < 256; i++) begin
            logic [31:0] junk = 32'(i) * 32'h0123_4567;
            do_walk({junk[31:20], 8'(i), junk[11:0]}, 1'b1, (i % 8) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule